// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches sixteen request lines and turns level changes on them into interrupt requests and event strobes. Each line picks one port out of sixteen with its own 4-bit source selector and then follows that port's pin with the same index as the line. The pin levels arrive already synchronized, as one flat vector. A simple register port sets the selectors, the trigger edges and the two masks, and it reads and clears the pending flags.

Each line has a small state machine with two states. LN_PRIME means the line has no valid previous sample. LN_ARMED means edges are being compared. Reset puts every line in LN_PRIME. LN_PRIME always moves to LN_ARMED on the next clock and takes its first sample in that cycle. LN_ARMED stays in LN_ARMED. A write that changes a line's selector field sends the line from either state back to LN_PRIME, so switching to a pin at a different level raises no edge. A qualifying edge does two things at the next clock. If the interrupt mask is set, it latches the line's pending flag. If the event mask is set, it produces a one-cycle event pulse. The interrupt request is the pending flag gated by the interrupt mask.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Reset has these effects. Every selector, mask and trigger enable reads 0. Every line selects port 0. `irq_req`, `evt_pulse` and the pending register are all 0.
- R2: Line n follows bit `p*16+n` of `pin_lvl`, where p is its selector field. The field sits in register address n/4 at bits `4*(n%4)+3 : 4*(n%4)`. Edges on other ports or other pins do not affect line n. The register reads back what was written.
- R3: Bit n of the rising-enable register (address 6) makes a 0-to-1 change on line n a qualifying edge. With the falling enable clear, a 1-to-0 change does nothing.
- R4: Bit n of the falling-enable register (address 7) makes a 1-to-0 change on line n a qualifying edge. With the rising enable clear, a 0-to-1 change does nothing.
- R5: When both enables are set, either direction of change qualifies.
- R6: A qualifying edge sets pending bit n (read at address 8) one clock after the pin change, but only when interrupt-mask bit n (address 4) is 1. With the mask at 0, the pending bit stays 0.
- R7: Writing 1 to a bit at address 8 clears that pending bit, and writing 0 has no effect. If a clear and a new qualifying edge land in the same cycle, the bit stays set.
- R8: `irq_req[n]` equals pending bit n ANDed with interrupt-mask bit n. Clearing the mask drops the request but keeps the pending bit.
- R9: When event-mask bit n (address 5) is 1, a qualifying edge gives `evt_pulse[n]` high for exactly one clock, starting one clock after the pin change. This does not depend on the interrupt mask or the pending bit. With the event mask at 0, there is no pulse.
- R10: A write that changes line n's selector produces no edge from the switch itself. The first compare happens two clocks after the write, against the new pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_lvl | input | 256 | Synchronized pin levels, port p pin n at bit p*16+n |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address: 0-3 selectors, 4 interrupt mask, 5 event mask, 6 rising enable, 7 falling enable, 8 pending (write 1 to clear) |
| reg_wdata | input | 16 | Write data, bit n for line n |
| reg_raddr | input | 4 | Read address, same map; unmapped reads 0 |
| reg_rdata | output | 16 | Combinational read data |
| irq_req | output | 16 | Per-line interrupt request |
| evt_pulse | output | 16 | Per-line one-clock event pulse |

## Verification
The hardest case to reach is a clear and a new edge arriving in the same cycle. The bench arranges it by leaving a pending flag set, returning the pin low while only rising edges are enabled, and then raising the pin in the same cycle as the write-one-to-clear. The selector switch is also hard to reach, because it must land on a pin sitting at the opposite level to the old one. The bench parks the two pins at different levels and then checks the event output for three cycles after the write.

// File: rtl/eic_pkg.sv
package eic_pkg;
    // Per-line sampling state: no valid previous sample vs. comparing edges
    typedef enum logic [0:0] {
        LN_PRIME = 1'b0,
        LN_ARMED = 1'b1
    } ln_state_e;
endpackage

// File: rtl/eic_regs.sv
module eic_regs #(
    parameter int NLINES = 16,
    parameter int SELW   = 4,
    parameter int AW     = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [NLINES-1:0]        wdata,
    input  logic [AW-1:0]            raddr,
    output logic [NLINES-1:0]        rdata,
    input  logic [NLINES-1:0]        pend,
    output logic [NLINES*SELW-1:0]   sel,
    output logic [NLINES-1:0]        imask,
    output logic [NLINES-1:0]        emask,
    output logic [NLINES-1:0]        ren,
    output logic [NLINES-1:0]        fen,
    output logic [NLINES-1:0]        clr,
    output logic [NLINES-1:0]        resel
);
    localparam int FPR     = NLINES / SELW;   // selector fields per register
    localparam int NSEL    = NLINES / FPR;    // selector registers
    localparam int A_IMASK = NSEL;
    localparam int A_EMASK = NSEL + 1;
    localparam int A_RISE  = NSEL + 2;
    localparam int A_FALL  = NSEL + 3;
    localparam int A_PEND  = NSEL + 4;

    logic [NLINES*SELW-1:0] sel_q;
    logic [NLINES-1:0]      imask_q, emask_q, rise_q, fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            imask_q <= '0;
            emask_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else if (we) begin
            for (int r = 0; r < NSEL; r++) begin
                if (int'(waddr) == r) sel_q[r*NLINES +: NLINES] <= wdata;
            end
            if (int'(waddr) == A_IMASK) imask_q <= wdata;
            if (int'(waddr) == A_EMASK) emask_q <= wdata;
            if (int'(waddr) == A_RISE)  rise_q  <= wdata;
            if (int'(waddr) == A_FALL)  fall_q  <= wdata;
        end
    end

    // A selector field that changes value re-primes its line
    for (genvar n = 0; n < NLINES; n++) begin : g_resel
        localparam int RI = n / FPR;
        assign resel[n] = we && (int'(waddr) == RI) &&
                          (wdata[(n % FPR)*SELW +: SELW] != sel_q[n*SELW +: SELW]);
    end

    assign clr   = (we && int'(waddr) == A_PEND) ? wdata : '0;
    assign sel   = sel_q;
    assign imask = imask_q;
    assign emask = emask_q;
    assign ren   = rise_q;
    assign fen   = fall_q;

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NSEL; r++) begin
            if (int'(raddr) == r) rdata = sel_q[r*NLINES +: NLINES];
        end
        if (int'(raddr) == A_IMASK) rdata = imask_q;
        if (int'(raddr) == A_EMASK) rdata = emask_q;
        if (int'(raddr) == A_RISE)  rdata = rise_q;
        if (int'(raddr) == A_FALL)  rdata = fall_q;
        if (int'(raddr) == A_PEND)  rdata = pend;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && imask_q == '0 && emask_q == '0 &&
                 rise_q == '0 && fall_q == '0));
endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
#(
    parameter int SELW  = 4,
    parameter int NPORT = 2**SELW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] pins,
    input  logic [SELW-1:0]  sel,
    input  logic             resel,
    input  logic             ren,
    input  logic             fen,
    input  logic             imask,
    input  logic             emask,
    input  logic             clr,
    output logic             pend,
    output logic             irq,
    output logic             evt
);
    ln_state_e st_q, st_d;
    logic      lvl, prev_q, pend_q, evt_q, hit;

    assign lvl = pins[sel];

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= LN_PRIME;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_PRIME: st_d = LN_ARMED;
            LN_ARMED: st_d = LN_ARMED;
        endcase
        if (resel) st_d = LN_PRIME;
    end

    assign hit = (st_q == LN_ARMED) &&
                 ((ren && lvl && !prev_q) || (fen && !lvl && prev_q));

    // Outputs: sample history, pending flag, event strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            pend_q <= (pend_q && !clr) || (hit && imask);
            evt_q  <= hit && emask;
        end
    end

    assign pend = pend_q;
    assign irq  = pend_q && imask;
    assign evt  = evt_q;

    assert_prime_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == LN_PRIME) |=> (!evt_q && !$rose(pend_q)));
    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr) |=> pend_q);
    assert_pend_mask_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(imask));
    assert_evt_mask_R9: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> $past(emask));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int NLINES = 16,
    parameter int SELW   = 4,
    parameter int AW     = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [(2**SELW)*NLINES-1:0]       pin_lvl,
    input  logic                              reg_we,
    input  logic [AW-1:0]                     reg_waddr,
    input  logic [NLINES-1:0]                 reg_wdata,
    input  logic [AW-1:0]                     reg_raddr,
    output logic [NLINES-1:0]                 reg_rdata,
    output logic [NLINES-1:0]                 irq_req,
    output logic [NLINES-1:0]                 evt_pulse
);
    localparam int NPORT = 2**SELW;

    logic [NLINES*SELW-1:0] sel;
    logic [NLINES-1:0]      imask, emask, ren, fen, clr, resel, pend;

    eic_regs #(.NLINES(NLINES), .SELW(SELW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata),
        .pend(pend), .sel(sel), .imask(imask), .emask(emask),
        .ren(ren), .fen(fen), .clr(clr), .resel(resel)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        logic [NPORT-1:0] col;
        for (genvar p = 0; p < NPORT; p++) begin : g_col
            assign col[p] = pin_lvl[p*NLINES + n];
        end
        eic_line #(.SELW(SELW), .NPORT(NPORT)) u_line (
            .clk(clk), .rst(rst), .pins(col),
            .sel(sel[n*SELW +: SELW]), .resel(resel[n]),
            .ren(ren[n]), .fen(fen[n]),
            .imask(imask[n]), .emask(emask[n]), .clr(clr[n]),
            .pend(pend[n]), .irq(irq_req[n]), .evt(evt_pulse[n])
        );
    end
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] pin_lvl = '0;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_waddr = '0;
    logic [15:0]  reg_wdata = '0;
    logic [3:0]   reg_raddr = '0;
    logic [15:0]  reg_rdata, irq_req, evt_pulse;

    edge_irq_ctrl uut (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .evt_pulse(evt_pulse)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          cyc;
        int          kind;   // 0 evt_pulse, 1 irq_req, 2 reg_rdata
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    // Monitor: pops items whose cycle has come and compares
    always @(negedge clk) begin
        cyc++;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t       it;
            logic [15:0] got;
            it  = q.pop_front();
            got = (it.kind == 0) ? evt_pulse : (it.kind == 1) ? irq_req : reg_rdata;
            checks++;
            if (got !== it.val) begin
                fails++;
                $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                         it.tag, it.kind, cyc, got, it.val);
            end
        end
    end

    task automatic expect_item(int kind, int dly, logic [15:0] v, string tag);
        item_t it;
        int    pos;
        it  = '{cyc + dly, kind, v, tag};
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > it.cyc) begin pos = i; break; end
        end
        q.insert(pos, it);
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [15:0] d);
        reg_we = 1'b1; reg_waddr = 4'(a); reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, logic [15:0] e, string tag);
        reg_raddr = 4'(a);
        expect_item(2, 1, e, tag);
        step();
    endtask

    task automatic pin(int idx, logic v);
        pin_lvl[idx] = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1: reset state
        expect_item(0, 1, 16'h0, "R1 evt");
        expect_item(1, 1, 16'h0, "R1 irq");
        for (int a = 0; a < 9; a++) rd(a, 16'h0, "R1 reg");

        // R3: rising-only on line 5 (port 0)
        wr(6, 16'h0020); wr(5, 16'h0020); wr(4, 16'h0020);
        pin(5, 1'b1);
        expect_item(0, 1, 16'h0020, "R3 evt");
        expect_item(1, 1, 16'h0020, "R3 irq");
        expect_item(0, 2, 16'h0000, "R9 one cycle");
        step(); step();
        pin(5, 1'b0);
        expect_item(0, 1, 16'h0000, "R3 fall ignored");
        step();
        rd(8, 16'h0020, "R6 pending");

        // R7: write-one-to-clear, set wins
        wr(8, 16'h0000);
        rd(8, 16'h0020, "R7 write zero");
        wr(8, 16'h0020);
        expect_item(1, 1, 16'h0000, "R7 irq cleared");
        rd(8, 16'h0000, "R7 cleared");
        pin(5, 1'b1); step();
        pin(5, 1'b0); step();
        pin(5, 1'b1);
        reg_we = 1'b1; reg_waddr = 4'd8; reg_wdata = 16'h0020;
        expect_item(1, 1, 16'h0020, "R7 set wins");
        step();
        reg_we = 1'b0;
        rd(8, 16'h0020, "R7 set wins pending");

        // R8: mask gates request, pending kept
        wr(4, 16'h0000);
        expect_item(1, 1, 16'h0000, "R8 masked");
        rd(8, 16'h0020, "R8 pending kept");
        wr(4, 16'h0020);
        expect_item(1, 1, 16'h0020, "R8 unmasked");
        step();
        wr(8, 16'h0020);
        pin(5, 1'b0); step();

        // R6/R9: event without interrupt, and interrupt without event
        wr(4, 16'h0000);
        pin(5, 1'b1);
        expect_item(0, 1, 16'h0020, "R9 evt no imask");
        expect_item(1, 1, 16'h0000, "R6 no irq");
        step();
        rd(8, 16'h0000, "R6 no pending when masked");
        pin(5, 1'b0); step();
        wr(4, 16'h0020); wr(5, 16'h0000);
        pin(5, 1'b1);
        expect_item(0, 1, 16'h0000, "R9 evt masked");
        expect_item(1, 1, 16'h0020, "R6 irq");
        step();
        wr(8, 16'h0020);
        pin(5, 1'b0); step();

        // R4: falling-only on line 9
        wr(6, 16'h0000); wr(7, 16'h0200); wr(5, 16'h0200); wr(4, 16'h0000);
        pin(9, 1'b1);
        expect_item(0, 1, 16'h0000, "R4 rise ignored");
        step();
        pin(9, 1'b0);
        expect_item(0, 1, 16'h0200, "R4 fall");
        expect_item(0, 2, 16'h0000, "R4 pulse end");
        step(); step();

        // R5: both edges on line 9
        wr(6, 16'h0200);
        pin(9, 1'b1);
        expect_item(0, 1, 16'h0200, "R5 rise");
        step(); step();
        pin(9, 1'b0);
        expect_item(0, 1, 16'h0200, "R5 fall");
        step(); step();

        // R2: line 6 from port 10
        wr(7, 16'h0000); wr(6, 16'h0040); wr(5, 16'h0040);
        wr(1, 16'h0A00);
        rd(1, 16'h0A00, "R2 readback");
        step();
        pin(6, 1'b1);
        expect_item(0, 1, 16'h0000, "R2 other port");
        step();
        pin(10*16 + 7, 1'b1);
        expect_item(0, 1, 16'h0000, "R2 other pin");
        step();
        pin(10*16 + 6, 1'b1);
        expect_item(0, 1, 16'h0040, "R2 selected pin");
        step(); step();

        // R10: selector switch onto a high pin gives no edge
        wr(6, 16'h0001); wr(5, 16'h0001);
        pin(3*16 + 0, 1'b1);
        step();
        expect_item(0, 1, 16'h0000, "R10 switch");
        expect_item(0, 2, 16'h0000, "R10 switch");
        expect_item(0, 3, 16'h0000, "R10 switch");
        wr(0, 16'h0003);
        step(); step();
        pin(3*16 + 0, 1'b0); step();
        pin(3*16 + 0, 1'b1);
        expect_item(0, 1, 16'h0001, "R10 real edge");
        step(); step(); step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule